// File: doc/BRIEF.md
# Atomic 512-bit Store Request Assembler

This block accepts one 32-bit instruction word for a store that moves a whole 64-byte block to memory in one indivisible write. It first decodes the word. A wrong fixed opcode field, a disabled feature or an illegal first data register makes it report an undefined-instruction fault and issue nothing. Otherwise it reads eight consecutive 64-bit general registers through a single register-file read port, one per cycle. It packs them into a 512-bit data word, the first register in the lowest doubleword, and byte-reverses each doubleword on its own when big-endian mode is selected.

After the data it reads the base register. A base field of 31 selects the stack pointer instead. The base must be 64-byte aligned. The stack pointer must also meet its own 16-byte rule, and that check comes first. A good instruction produces one store request carrying address, data and a tag-check flag. The request is held until the memory side takes it. The store returns no status, so nothing is written back to the registers.

Top module: `st512_store_assembler`

## Requirements
- R1: An instruction is accepted when `in_valid` and `in_ready` are both high. Its bits [31:10] must equal 1111100000111111100100. Any other value gives a fault with `flt_code` = 1 (undefined) and no request. Bits [9:5] are the base field and bits [4:0] the first data register field.
- R2: When `feat_en` is low at acceptance, the instruction faults with code 1 and no request.
- R3: A first data register field whose bits [4:3] are 2'b11, or whose bit 0 is 1, faults with code 1 and no request.
- R4: For a legal instruction with first register t, `rf_raddr` equals t+k in the k-th cycle after acceptance (k = 0..7), then equals the base field. `req_data[64*k+63:64*k]` holds register t+k.
- R5: When `big_endian` is high at acceptance, each doubleword has its eight bytes reversed before placement. The doubleword order does not change.
- R6: The request address is `sp_value` when the base field is 31. Otherwise it is the contents of the register named by the base field.
- R7: `req_tagchk` is high exactly when the base field is not 31.
- R8: A base address with any of bits [5:0] nonzero gives a fault with `flt_code` = 3 and no request.
- R9: With base field 31 and `sp_value[3:0]` nonzero, the fault code is 2. This takes priority over code 3.
- R10: Once `req_valid` is high, it and its address, data and flag stay unchanged until a cycle with `req_ready` high. `in_ready` is low from acceptance until the request is taken or the fault pulse ends.
- R11: An undefined fault appears in the first cycle after acceptance. A request or an alignment fault appears in the tenth cycle after acceptance. `flt_valid` lasts exactly one cycle, and `req_valid` and `flt_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, will accept an instruction |
| in_insn | input | 32 | Instruction word |
| feat_en | input | 1 | 64-byte store feature enabled |
| big_endian | input | 1 | Byte-reverse each doubleword |
| sp_value | input | 64 | Current stack pointer |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 64 | Register-file read data, same cycle as address |
| req_valid | output | 1 | Store request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 64 | Store address |
| req_data | output | 512 | Store data |
| req_tagchk | output | 1 | Tag check wanted for this store |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_code | output | 2 | 1 undefined, 2 stack alignment, 3 block alignment |

## Verification
The assertions assume that the register file answers in the same cycle as the address and holds its contents while an instruction is in flight. They also assume that `sp_value` is steady during the base cycle and that `req_ready` is meaningful only while a request is pending. The bench models the register file as a combinational array that changes only between instructions. It changes the stack pointer only before an offer, and it raises `req_ready` only after sampling a pending request. Across these sweeps it walks every first-register value, several base choices and both endian modes. It also flips each opcode bit and covers each misalignment offset.

// File: rtl/st512_pkg.sv
package st512_pkg;
    localparam int INSN_W   = 32;
    localparam int REG_AW   = 5;
    localparam int OPC_W    = 22;
    localparam logic [OPC_W-1:0] OPC_FIXED = 22'b1111100000111111100100;
    localparam logic [REG_AW-1:0] SP_SEL = 5'd31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_BASE,
        ST_REQ,
        ST_FAULT
    } fsm_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_UNDEF   = 2'd1,
        FLT_SPALIGN = 2'd2,
        FLT_ALIGN   = 2'd3
    } fault_e;
endpackage

// File: rtl/st512_decode.sv
module st512_decode
    import st512_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              feat_en,
    output logic              legal,
    output logic [REG_AW-1:0] rt,
    output logic [REG_AW-1:0] rn
);
    logic opc_hit;
    logic rt_bad;

    always_comb begin
        rt      = insn[REG_AW-1:0];
        rn      = insn[2*REG_AW-1:REG_AW];
        opc_hit = (insn[INSN_W-1:2*REG_AW] == OPC_FIXED);
        // first register must be even and the run of eight must stay below 30
        rt_bad  = (rt[4:3] == 2'b11) || rt[0];
        legal   = opc_hit && feat_en && !rt_bad;
    end
endmodule

// File: rtl/st512_bswap.sv
module st512_bswap #(
    parameter int W = 64
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    logic [W-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/st512_base_check.sv
module st512_base_check
    import st512_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int OFSW     = 6,
    parameter int SPW      = 4
) (
    input  logic [REG_AW-1:0] rn,
    input  logic [XLEN-1:0]   sp_value,
    input  logic [XLEN-1:0]   reg_value,
    output logic [XLEN-1:0]   base,
    output logic              tagchk,
    output fault_e            fault
);
    logic use_sp;
    logic sp_mis;
    logic blk_mis;

    always_comb begin
        use_sp  = (rn == SP_SEL);
        base    = use_sp ? sp_value : reg_value;
        tagchk  = !use_sp;
        sp_mis  = use_sp && (sp_value[SPW-1:0] != '0);
        blk_mis = (base[OFSW-1:0] != '0);
        if (sp_mis)       fault = FLT_SPALIGN;
        else if (blk_mis) fault = FLT_ALIGN;
        else              fault = FLT_NONE;
    end
endmodule

// File: rtl/st512_store_assembler.sv
module st512_store_assembler
    import st512_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int BEATS    = 8,
    parameter int SP_ALIGN = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [INSN_W-1:0]      in_insn,
    input  logic                   feat_en,
    input  logic                   big_endian,
    input  logic [XLEN-1:0]        sp_value,
    output logic [REG_AW-1:0]      rf_raddr,
    input  logic [XLEN-1:0]        rf_rdata,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [XLEN-1:0]        req_addr,
    output logic [XLEN*BEATS-1:0]  req_data,
    output logic                   req_tagchk,
    output logic                   flt_valid,
    output logic [1:0]             flt_code
);
    localparam int DATAW  = XLEN * BEATS;
    localparam int IDXW   = $clog2(BEATS);
    localparam int OFSW   = $clog2(DATAW / 8);
    localparam int SPW    = $clog2(SP_ALIGN);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BEATS - 1);

    typedef struct packed {
        fsm_e              st;
        logic [IDXW-1:0]   idx;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rn;
        logic              be;
        logic [DATAW-1:0]  data;
        logic [XLEN-1:0]   addr;
        logic              tag;
        fault_e            fcode;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              dec_legal;
    logic [REG_AW-1:0] dec_rt;
    logic [REG_AW-1:0] dec_rn;
    logic [XLEN-1:0]   lane_val;
    logic [XLEN-1:0]   chk_base;
    logic              chk_tag;
    fault_e            chk_fault;

    st512_decode u_dec (
        .insn    (in_insn),
        .feat_en (feat_en),
        .legal   (dec_legal),
        .rt      (dec_rt),
        .rn      (dec_rn)
    );

    st512_bswap #(.W(XLEN)) u_swap (
        .en   (ctx_q.be),
        .din  (rf_rdata),
        .dout (lane_val)
    );

    st512_base_check #(.XLEN(XLEN), .OFSW(OFSW), .SPW(SPW)) u_base (
        .rn        (ctx_q.rn),
        .sp_value  (sp_value),
        .reg_value (rf_rdata),
        .base      (chk_base),
        .tagchk    (chk_tag),
        .fault     (chk_fault)
    );

    // read address: data run during gather, base register otherwise
    always_comb begin
        if (ctx_q.st == ST_GATHER)
            rf_raddr = ctx_q.rt + REG_AW'(ctx_q.idx);
        else
            rf_raddr = ctx_q.rn;
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!dec_legal) begin
                        ctx_d.st    = ST_FAULT;
                        ctx_d.fcode = FLT_UNDEF;
                    end else begin
                        ctx_d.st    = ST_GATHER;
                        ctx_d.idx   = '0;
                        ctx_d.rt    = dec_rt;
                        ctx_d.rn    = dec_rn;
                        ctx_d.be    = big_endian;
                        ctx_d.data  = '0;
                        ctx_d.fcode = FLT_NONE;
                    end
                end
            end
            ST_GATHER: begin
                ctx_d.data[ctx_q.idx*XLEN +: XLEN] = lane_val;
                if (ctx_q.idx == LAST_IDX) ctx_d.st  = ST_BASE;
                else                       ctx_d.idx = ctx_q.idx + 1'b1;
            end
            ST_BASE: begin
                ctx_d.addr = chk_base;
                ctx_d.tag  = chk_tag;
                if (chk_fault != FLT_NONE) begin
                    ctx_d.st    = ST_FAULT;
                    ctx_d.fcode = chk_fault;
                end else begin
                    ctx_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (req_ready) ctx_d.st = ST_IDLE;
            end
            ST_FAULT: begin
                ctx_d.st    = ST_IDLE;
                ctx_d.fcode = FLT_NONE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q       <= '0;
            ctx_q.st    <= ST_IDLE;
            ctx_q.fcode <= FLT_NONE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign in_ready   = (ctx_q.st == ST_IDLE);
    assign req_valid  = (ctx_q.st == ST_REQ);
    assign req_addr   = ctx_q.addr;
    assign req_data   = ctx_q.data;
    assign req_tagchk = ctx_q.tag;
    assign flt_valid  = (ctx_q.st == ST_FAULT);
    assign flt_code   = (ctx_q.st == ST_FAULT) ? ctx_q.fcode : FLT_NONE;

    // R10: pending request is frozen until taken
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                   && $stable(req_data) && $stable(req_tagchk));

    // R10: no new instruction while a request waits
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    // R8: an issued request is block aligned
    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[OFSW-1:0] == '0));

    // R11: fault pulse lasts one cycle and never overlaps a request
    p_flt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_valid && req_valid));

    // R1: an undefined word leads straight to a code 1 fault
    p_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !dec_legal |=> flt_valid && flt_code == 2'd1);

    // R4: gather addresses step by one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctx_q.st == ST_GATHER) && ctx_q.st == ST_GATHER
        |-> rf_raddr == $past(rf_raddr) + 1'b1);
endmodule

// File: tb/st512_store_assembler_bench.sv
module st512_store_assembler_bench;
    localparam logic [21:0] OPC = 22'b1111100000111111100100;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  in_insn;
    logic         feat_en;
    logic         big_endian;
    logic [63:0]  sp_value;
    logic [4:0]   rf_raddr;
    logic [63:0]  rf_rdata;
    logic         req_valid;
    logic         req_ready;
    logic [63:0]  req_addr;
    logic [511:0] req_data;
    logic         req_tagchk;
    logic         flt_valid;
    logic [1:0]   flt_code;

    logic [63:0] regs [32];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    st512_store_assembler u_st512_store_assembler (
        .clk, .rst_n, .in_valid, .in_ready, .in_insn, .feat_en, .big_endian,
        .sp_value, .rf_raddr, .rf_rdata, .req_valid, .req_ready, .req_addr,
        .req_data, .req_tagchk, .flt_valid, .flt_code
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, act %0d exp <150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act %h exp %h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] rev8(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] rn);
        return {OPC, rn, rt};
    endfunction

    task automatic reg_init();
        for (int i = 0; i < 32; i++)
            regs[i] = (64'h0123_4567_89AB_CDEF * 64'(i + 1) + 64'(i * 77)) & ~64'h3F;
    endtask

    task automatic run(input logic [31:0] insn, input bit fe, input bit be,
                       input logic [63:0] sp, input int hold);
        logic [4:0]  rt = insn[4:0];
        logic [4:0]  rn = insn[9:5];
        bit          legal;
        logic [63:0] base;
        int          ecode;
        legal = (insn[31:10] == OPC) && fe && (rt[4:3] != 2'b11) && !rt[0];
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 idle ready", 64'(in_ready), 64'd1);
        in_insn = insn; feat_en = fe; big_endian = be; sp_value = sp; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R10 busy after accept", 64'(in_ready), 64'd0);
        if (!legal) begin
            chk(flt_valid && flt_code == 2'd1 && !req_valid,
                insn[31:10] != OPC ? "R1 opcode undef" : (!fe ? "R2 feature off" : "R3 rt illegal"),
                64'({flt_valid, flt_code}), 64'({1'b1, 2'd1}));
            @(negedge clk);
            chk(!flt_valid && in_ready, "R11 fault one cycle", 64'({flt_valid, in_ready}), 64'b01);
            return;
        end
        for (int k = 0; k < 9; k++) begin
            logic [4:0] ea = (k < 8) ? rt + 5'(k) : rn;
            chk(rf_raddr == ea, "R4 read order", 64'(rf_raddr), 64'(ea));
            chk(!req_valid && !flt_valid, "R11 early output", 64'({req_valid, flt_valid}), 64'd0);
            @(negedge clk);
        end
        base = (rn == 5'd31) ? sp : regs[rn];
        if (rn == 5'd31 && sp[3:0] != 4'd0) ecode = 2;
        else if (base[5:0] != 6'd0)         ecode = 3;
        else                                ecode = 0;
        if (ecode != 0) begin
            chk(flt_valid && flt_code == 2'(ecode) && !req_valid,
                ecode == 2 ? "R9 sp alignment" : "R8 block alignment",
                64'({req_valid, flt_valid, flt_code}), 64'({1'b0, 1'b1, 2'(ecode)}));
            @(negedge clk);
            chk(!flt_valid && in_ready, "R11 fault one cycle", 64'({flt_valid, in_ready}), 64'b01);
            return;
        end
        chk(req_valid && !flt_valid, "R11 request latency", 64'({req_valid, flt_valid}), 64'b10);
        chk(req_addr == base, "R6 base select", req_addr, base);
        chk(req_tagchk == (rn != 5'd31), "R7 tag flag", 64'(req_tagchk), 64'(rn != 5'd31));
        for (int k = 0; k < 8; k++) begin
            logic [63:0] ed = be ? rev8(regs[rt + 5'(k)]) : regs[rt + 5'(k)];
            chk(req_data[64*k +: 64] == ed, be ? "R5 endian lane" : "R4 packing lane",
                req_data[64*k +: 64], ed);
        end
        for (int h = 0; h < hold; h++) begin
            logic [63:0] a0 = req_addr;
            @(negedge clk);
            chk(req_valid && !in_ready && req_addr == a0, "R10 hold request",
                64'({req_valid, in_ready}), 64'b10);
        end
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid && in_ready, "R10 released", 64'({req_valid, in_ready}), 64'b01);
    endtask

    initial begin
        logic [4:0] rns [5] = '{5'd0, 5'd5, 5'd13, 5'd30, 5'd31};
        logic [63:0] sp_ok = 64'hFFFF_0000_1234_5640;
        rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; feat_en = 1'b1;
        big_endian = 1'b0; sp_value = sp_ok; req_ready = 1'b0;
        reg_init();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(in_ready && !req_valid && !flt_valid, "R10 reset state",
            64'({in_ready, req_valid, flt_valid}), 64'b100);

        // R4 R5 R6 R7 R10: every legal first register, several bases, both endians
        for (int rt = 0; rt <= 22; rt += 2)
            for (int j = 0; j < 5; j++)
                for (int be = 0; be < 2; be++)
                    run(mk(5'(rt), rns[j]), 1'b1, be[0], sp_ok, (rt + j) % 4);

        // R3: every first register value
        for (int rt = 0; rt < 32; rt++) run(mk(5'(rt), 5'd3), 1'b1, 1'b0, sp_ok, 0);

        // R2: feature disabled
        for (int rt = 0; rt <= 22; rt += 11) run(mk(5'(rt & 30), 5'd31), 1'b0, 1'b0, sp_ok, 0);

        // R1: each opcode bit flipped
        for (int b = 10; b < 32; b++) run(mk(5'd4, 5'd2) ^ (32'd1 << b), 1'b1, 1'b0, sp_ok, 0);

        // R8: misaligned register base
        for (int s = 0; s < 6; s++) begin
            regs[7] = regs[7] | (64'd1 << s);
            run(mk(5'd8, 5'd7), 1'b1, 1'b0, sp_ok, 0);
            reg_init();
        end

        // R9: stack pointer alignment priority
        for (int s = 0; s < 6; s++) run(mk(5'd0, 5'd31), 1'b1, 1'b1, sp_ok | (64'd1 << s), 0);
        run(mk(5'd2, 5'd31), 1'b1, 1'b0, sp_ok | 64'h3F, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule